// File: doc/BRIEF.md
# Staged Clock Source Reprogramming Sequencer

This block changes one clock-control register safely. A requester hands over the register address, the word the register holds now, the word it should hold, and a mask that marks the source-select field. The sequencer then issues two register writes. The first write is a staged word that takes only the masked select bits from the new word and keeps every other bit from the old word. The second write is the complete new word.

After each write the block waits one frame, using the vertical-sync status as its time base. A wait first sees the sync flag go low and then sees it go high again. A flag that never moves cannot hang the block: each polling phase gives up after a bounded number of samples, the sequence continues, and a sticky status bit records that this happened.

A request changes one clock source. Changes to several sources must be sent as separate, back-to-back requests. The block takes a request only when idle. It holds `busy` until the final settle wait ends, then pulses `done`.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `busy`, `done`, `wr_en` and `timeout_seen` are 0.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both 1. Requests presented while `busy` is 1 cause no write and are lost.
- R3: The first write of a request goes to `req_addr` with data `(req_old & ~req_sel_mask) | (req_new & req_sel_mask)`.
- R4: The second write goes to the same address with data `req_new`. It is issued only after the first settle wait has finished.
- R5: A settle wait ends only after the synchronised vsync flag has been sampled low and then sampled high (SYNC_STAGES flops of delay). No write and no `done` happen while the flag has not completed that low-then-high pattern.
- R6: Each polling phase of a settle wait (waiting for low, waiting for high) gives up after POLL_LIMIT samples without the expected level. The sequence then goes on as if the level had been seen.
- R7: `timeout_seen` becomes 1 when any polling phase of the current request ends by R6. It stays 1 until the next request is accepted, which clears it.
- R8: `busy` is 1 from the cycle after acceptance until the final settle wait ends. `done` is a one-cycle pulse in the cycle `busy` falls. No write follows `done` without a new request.
- R9: Each accepted request produces exactly two writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Clock-control register address |
| req_old | input | DATA_W | Current register contents |
| req_new | input | DATA_W | Target register contents |
| req_sel_mask | input | DATA_W | Bits forming the source-select field |
| vsync_active | input | 1 | Vertical-sync active flag (asynchronous) |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_seen | output | 1 | A wait phase of this request timed out |

## Verification
The bench holds the vsync flag at fixed levels at chosen moments. This shows that the full write and `done` appear only after a low-then-high pattern. A design that waited on one edge only, or skipped the first settle wait, would write the full word early. Stuck-high and stuck-low flags exercise each polling phase's give-up path. A design that hung there would never finish, and one that did not mark the timeout would leave `timeout_seen` low. The bench also checks that a later clean request clears the bit. Requests offered while busy must leave no extra write in the scoreboard, and masks placed at several bit positions show whether the staged word takes the wrong bits from the old or the new word.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_STAGE,
      SQ_SETTLE1,
      SQ_FULL,
      SQ_SETTLE2
   } seq_state_t;

   typedef enum logic [1:0] {
      VW_IDLE,
      VW_LOW,
      VW_HIGH
   } vwait_state_t;
endpackage

// File: rtl/clkseq_merge.sv
module clkseq_merge #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [DATA_W-1:0] sel_mask,
   output logic [DATA_W-1:0] staged_word
);
   // select bits come from the target, divider/shift bits stay as they are
   assign staged_word = (old_word & ~sel_mask) | (new_word & sel_mask);
endmodule

// File: rtl/clkseq_vsync_wait.sv
module clkseq_vsync_wait
   import clkseq_pkg::*;
#(
   parameter int POLL_LIMIT  = 10000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync_raw,
   input  logic start,
   output logic fin,
   output logic tmo_evt
);
   localparam int CNT_W = $clog2(POLL_LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_LIMIT - 1);

   generate
      if (POLL_LIMIT < 2) begin : g_bad_limit
         $error("POLL_LIMIT must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic vs;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign vs = vsync_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], vsync_raw} >> 0;
         end
         assign vs = sh[SYNC_STAGES-1];
      end
   endgenerate

   vwait_state_t     st;
   logic [CNT_W-1:0] cnt;
   logic             at_last;

   assign at_last = (cnt == LAST);

   always_comb begin
      fin     = (st == VW_HIGH) && (vs || at_last);
      tmo_evt = ((st == VW_LOW)  &&  vs && at_last) ||
                ((st == VW_HIGH) && !vs && at_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= VW_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            VW_IDLE: begin
               cnt <= '0;
               if (start) st <= VW_LOW;
            end
            VW_LOW: begin
               if (!vs || at_last) begin
                  st  <= VW_HIGH;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            VW_HIGH: begin
               if (vs || at_last) begin
                  st  <= VW_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= VW_IDLE;
         endcase
      end
   end

   // R6: a polling phase never runs past its sample budget
   p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st != VW_IDLE) |-> (cnt < CNT_W'(POLL_LIMIT)));

   // R5: the high-waiting phase is only ever entered from the low-waiting phase
   p_low_then_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == VW_HIGH && $past(st) != VW_HIGH) |-> ($past(st) == VW_LOW));

   p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (st == VW_IDLE));
endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
   import clkseq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_old,
   input  logic [DATA_W-1:0] req_new,
   input  logic [DATA_W-1:0] req_mask,
   output logic              req_ready,
   output logic [DATA_W-1:0] old_q,
   output logic [DATA_W-1:0] new_q,
   output logic [DATA_W-1:0] mask_q,
   input  logic [DATA_W-1:0] staged_word,
   output logic              wait_start,
   input  logic              wait_fin,
   input  logic              wait_tmo,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic              timeout_seen
);
   seq_state_t        st;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;

   assign req_ready = (st == SQ_IDLE);
   assign busy      = (st != SQ_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      wr_en      = (st == SQ_STAGE) || (st == SQ_FULL);
      wait_start = wr_en;
      wr_addr    = addr_q;
      wr_data    = (st == SQ_FULL) ? new_q : staged_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= SQ_IDLE;
         addr_q       <= '0;
         old_q        <= '0;
         new_q        <= '0;
         mask_q       <= '0;
         done         <= 1'b0;
         timeout_seen <= 1'b0;
      end else begin
         done <= 1'b0;
         if (wait_tmo) timeout_seen <= 1'b1;
         case (st)
            SQ_IDLE: if (accept) begin
               addr_q       <= req_addr;
               old_q        <= req_old;
               new_q        <= req_new;
               mask_q       <= req_mask;
               timeout_seen <= 1'b0;
               st           <= SQ_STAGE;
            end
            SQ_STAGE:   st <= SQ_SETTLE1;
            SQ_SETTLE1: if (wait_fin) st <= SQ_FULL;
            SQ_FULL:    st <= SQ_SETTLE2;
            SQ_SETTLE2: if (wait_fin) begin
               st   <= SQ_IDLE;
               done <= 1'b1;
            end
            default:    st <= SQ_IDLE;
         endcase
      end
   end

   // R3: staged word keeps every non-select bit of the old register word
   p_stage_keeps_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_STAGE) |-> ((wr_data & ~mask_q) == (old_q & ~mask_q)));

   // R4: the two writes of a request are never back to back
   p_writes_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R8: completion is a single-cycle pulse
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: busy only starts after a presented request
   p_accept_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |-> $past(req_valid));

   // R7: the timeout mark survives until a new request is taken
   p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_seen && !accept) |=> timeout_seen);
endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 12,
   parameter int POLL_LIMIT  = 10000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_old,
   input  logic [DATA_W-1:0] req_new,
   input  logic [DATA_W-1:0] req_sel_mask,
   input  logic              vsync_active,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic              timeout_seen
);
   generate
      if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("DATA_W and ADDR_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] old_q, new_q, mask_q, staged_word;
   logic              wait_start, wait_fin, wait_tmo;

   clkseq_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word    (old_q),
      .new_word    (new_q),
      .sel_mask    (mask_q),
      .staged_word (staged_word)
   );

   clkseq_vsync_wait #(
      .POLL_LIMIT  (POLL_LIMIT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .vsync_raw (vsync_active),
      .start     (wait_start),
      .fin       (wait_fin),
      .tmo_evt   (wait_tmo)
   );

   clkseq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .req_old      (req_old),
      .req_new      (req_new),
      .req_mask     (req_sel_mask),
      .req_ready    (req_ready),
      .old_q        (old_q),
      .new_q        (new_q),
      .mask_q       (mask_q),
      .staged_word  (staged_word),
      .wait_start   (wait_start),
      .wait_fin     (wait_fin),
      .wait_tmo     (wait_tmo),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .busy         (busy),
      .done         (done),
      .timeout_seen (timeout_seen)
   );
endmodule

// File: tb/tb_clk_switch_seq.sv
`timescale 1ns/1ps
module tb_clk_switch_seq;
   localparam int DW   = 16;
   localparam int AW   = 6;
   localparam int POLL = 40;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_old = '0, req_new = '0, req_sel_mask = '0;
   logic          vsync_active = 1'b0;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          busy, done, timeout_seen;

   always #2.5 clk = ~clk;

   clk_switch_seq #(.DATA_W(DW), .ADDR_W(AW), .POLL_LIMIT(POLL), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_old(req_old), .req_new(req_new),
      .req_sel_mask(req_sel_mask), .vsync_active(vsync_active),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done), .timeout_seen(timeout_seen)
   );

   typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
   wr_t exp_q[$];

   int n_chk = 0, n_bad = 0, wr_seen = 0, done_seen = 0;
   bit finished = 0;
   bit done_prev = 0;

   // vsync source: automatic frame pattern or a forced level
   bit vs_auto = 1'b0;
   bit vs_force = 1'b0;
   initial begin
      int ph = 0;
      forever begin
         @(posedge clk); #1;
         ph = (ph + 1) % 24;
         vsync_active = vs_auto ? (ph < 6) : vs_force;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected writes and checks completion pulses
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            wr_seen++;
            if (exp_q.size() == 0) check(1'b0, "R9 R2 unexpected write", {26'd0, wr_addr}, 32'd0);
            else begin
               wr_t e;
               e = exp_q.pop_front();
               check(wr_addr == e.a, "R3 R4 write address", {26'd0, wr_addr}, {26'd0, e.a});
               check(wr_data == e.d, "R3 R4 write data", {16'd0, wr_data}, {16'd0, e.d});
            end
         end
         if (done) begin
            done_seen++;
            check(!done_prev, "R8 done longer than one cycle", 32'd1, 32'd0);
            check(exp_q.size() == 0, "R8 R9 done before both writes", exp_q.size(), 32'd0);
            check(!busy, "R8 busy still high at done", {31'd0, busy}, 32'd0);
         end
         done_prev = done;
      end
   end

   task automatic do_req(input logic [AW-1:0] a, input logic [DW-1:0] o, input logic [DW-1:0] n,
                         input logic [DW-1:0] m);
      wr_t s, f;
      s.a = a; s.d = (o & ~m) | (n & m);
      f.a = a; f.d = n;
      exp_q.push_back(s);
      exp_q.push_back(f);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_old = o; req_new = n; req_sel_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int d0 = done_seen;
      int k = 0;
      while (done_seen == d0 && k < 3000) begin
         @(negedge clk); k++;
      end
      check(done_seen != d0, tag, done_seen, d0 + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready && !busy && !done && !wr_en && !timeout_seen, "R1 reset outputs",
            {27'd0, req_ready, busy, done, wr_en, timeout_seen}, 32'b10000);

      // normal requests with a running frame pattern, masks at several positions
      vs_auto = 1'b1;
      do_req(6'h05, 16'h1234, 16'hABCD, 16'h0001);
      wait_done("R4 R8 normal request completes");
      check(!timeout_seen, "R7 no timeout with live vsync", {31'd0, timeout_seen}, 32'd0);
      do_req(6'h21, 16'hF0F0, 16'h0F0F, 16'h2000);
      wait_done("R3 mask bit 13 request completes");
      do_req(6'h3F, 16'hFFFF, 16'h0000, 16'h00F0);
      wait_done("R3 nibble mask request completes");

      // R2: requests offered while busy are ignored
      w0 = wr_seen;
      do_req(6'h11, 16'h0000, 16'h5555, 16'h0100);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 6'h2A; req_old = 16'h7777; req_new = 16'h8888; req_sel_mask = 16'hFFFF;
      repeat (6) @(negedge clk);
      check(busy, "R8 busy during sequence", {31'd0, busy}, 32'd1);
      req_valid = 1'b0;
      wait_done("R2 request completes despite extra offers");
      repeat (60) @(negedge clk);
      check(wr_seen - w0 == 2, "R2 R9 write count with offers while busy", wr_seen - w0, 32'd2);

      // R5: manual vsync, writes gated by low-then-high
      vs_auto = 1'b0; vs_force = 1'b1;
      repeat (5) @(negedge clk);
      w0 = wr_seen;
      do_req(6'h0A, 16'h00FF, 16'hFF00, 16'h8000);
      repeat (12) @(negedge clk);
      check(wr_seen - w0 == 1, "R5 no full write while flag high", wr_seen - w0, 32'd1);
      vs_force = 1'b0;
      repeat (12) @(negedge clk);
      check(wr_seen - w0 == 1, "R5 no full write while flag low", wr_seen - w0, 32'd1);
      vs_force = 1'b1;
      repeat (10) @(negedge clk);
      check(wr_seen - w0 == 2, "R4 full write after low then high", wr_seen - w0, 32'd2);
      check(busy && done_seen >= 0, "R5 still busy in final settle", {31'd0, busy}, 32'd1);
      w0 = done_seen;
      repeat (12) @(negedge clk);
      check(done_seen == w0 && busy, "R5 no done while flag high", done_seen - w0, 32'd0);
      vs_force = 1'b0;
      repeat (12) @(negedge clk);
      check(done_seen == w0 && busy, "R5 no done while flag low", done_seen - w0, 32'd0);
      vs_force = 1'b1;
      repeat (10) @(negedge clk);
      check(done_seen == w0 + 1 && !busy, "R8 done after final settle", done_seen - w0, 32'd1);
      check(!timeout_seen, "R7 clean manual waits leave no timeout", {31'd0, timeout_seen}, 32'd0);

      // R6: stuck high, low-waiting phase gives up
      vs_force = 1'b1;
      do_req(6'h07, 16'hAAAA, 16'h5555, 16'h0003);
      wait_done("R6 stuck-high flag still completes");
      check(timeout_seen, "R7 timeout marked for stuck high", {31'd0, timeout_seen}, 32'd1);
      repeat (20) @(negedge clk);
      check(timeout_seen, "R7 timeout mark stays while idle", {31'd0, timeout_seen}, 32'd1);

      // R6: stuck low, high-waiting phase gives up
      vs_force = 1'b0;
      do_req(6'h08, 16'h1111, 16'h2222, 16'h000F);
      wait_done("R6 stuck-low flag still completes");
      check(timeout_seen, "R7 timeout marked for stuck low", {31'd0, timeout_seen}, 32'd1);

      // R7: a clean request clears the mark
      vs_auto = 1'b1;
      do_req(6'h09, 16'h3C3C, 16'hC3C3, 16'h0400);
      @(negedge clk);
      check(!timeout_seen, "R7 mark cleared on accept", {31'd0, timeout_seen}, 32'd0);
      wait_done("R8 clean request after timeouts");
      check(!timeout_seen, "R7 clean request ends without timeout", {31'd0, timeout_seen}, 32'd0);

      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R9 all expected writes seen", exp_q.size(), 32'd0);
      check(req_ready && !busy, "R8 idle at end", {30'd0, req_ready, busy}, 32'b10);

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule